// File: doc/BRIEF.md
# Attribute Mailbox with Four-Phase Handshake

This block lets a host reach the internal attributes of one transceiver lane through two 32-bit registers instead of a wide direct register map. The host writes a command word that carries an attribute code, a write flag, a request strobe and a 16-bit payload. It then polls a status word until the block reports the transaction as serviced. For a read, the status word also carries the 16-bit answer. The host then drops the strobe and waits for the acknowledge to fall, which closes a four-phase request/acknowledge cycle.

On the lane side the block launches each accepted request as a single-cycle pulse on an attribute port. It then waits any number of cycles for the target's response-valid strobe. The code, direction and payload are latched at launch, so host writes during a transaction never disturb the target.

Top module: `attr_mailbox`

## Requirements
- R1: The command register sits at host offset 0x00 and the status register at offset 0x04. A read of the command register returns the last word written to it, and a read of any other offset returns zero. Read data appears on host_rdata the cycle after host_rd and holds until the next read.
- R2: Command word fields are: code in bits 7:0, write flag in bit 13 (1 = write, 0 = read), request strobe in bit 15, and payload in bits 31:16. When the strobe is seen in the idle state, the block emits exactly one attr_valid pulse of one cycle, presenting that code, write flag and payload.
- R3: Status word fields are: busy in bit 14, acknowledge in bit 15, and response data in bits 31:16. All other bits read zero. After reset the status word is all zero.
- R4: Busy is 1 from launch until the response returns, and acknowledge is 0 during that time. Busy and acknowledge are never 1 together.
- R5: Acknowledge rises the cycle after attr_rsp_valid is seen during a transaction. For a read, the response field then holds the attr_rdata captured with that strobe. For a write, the response field is zero.
- R6: Acknowledge stays 1 while the request strobe stays set. It falls, and the response field returns to zero, the cycle after the host's clear of the strobe is registered.
- R7: A request strobe written while busy or while acknowledge is high starts no new transaction. A new transaction starts only once acknowledge is 0 and the strobe is set.
- R8: The response field is stable for as long as acknowledge is high. attr_code, attr_write and attr_wdata keep their values from launch until the next launch, whatever the host writes meanwhile.
- R9: A response may arrive in the same cycle as attr_valid or any number of cycles later. An attr_rsp_valid seen outside a transaction changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| attr_valid | output | 1 | One-cycle attribute request pulse |
| attr_write | output | 1 | Request direction, 1 = write |
| attr_code | output | 8 | Attribute code |
| attr_wdata | output | 16 | Attribute write payload |
| attr_rsp_valid | input | 1 | Target response strobe |
| attr_rdata | input | 16 | Target read data, valid with attr_rsp_valid |

## Verification
The embedded assertions check these rules on every cycle:
- busy and acknowledge are mutually exclusive;
- attr_valid lasts a single cycle and occurs only after an idle cycle with acknowledge low;
- acknowledge follows a response strobe, stays up while the strobe is set and falls once it is cleared;
- the response field and the latched attribute fields stay stable.

The bench scenarios are needed to show the data path end to end. They confirm that the code and payload the host wrote reach the target, and that read data comes back in the right field. They also cover a strobe rewritten during busy or acknowledge, which launches nothing, and a stray response while idle, which leaves the status at zero, each across response latencies from zero to several cycles.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int WORD_W  = 32;
    localparam int CODE_W  = 8;
    localparam int PAY_W   = 16;
    localparam int REQ_BIT = 15;
    localparam int BSY_BIT = 14;
    localparam int WR_BIT  = 13;
    localparam int PAY_LSB = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_ACK   = 2'd3
    } mbx_state_e;

    typedef struct packed {
        logic              write;
        logic [CODE_W-1:0] code;
        logic [PAY_W-1:0]  payload;
    } mbx_cmd_t;
endpackage

// File: rtl/mbx_host_regs.sv
module mbx_host_regs #(
    parameter int               ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] CMD_OFS = 'h0,
    parameter logic [ADDR_W-1:0] STS_OFS = 'h4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_wr,
    input  logic                       host_rd,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [mbx_pkg::WORD_W-1:0] host_wdata,
    input  logic [mbx_pkg::WORD_W-1:0] status_word,
    output logic [mbx_pkg::WORD_W-1:0] cmd_word,
    output logic [mbx_pkg::WORD_W-1:0] host_rdata
);
    import mbx_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] rdata;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (host_wr && host_addr == CMD_OFS) begin
            regs_d.cmd = host_wdata;
        end
        if (host_rd) begin
            if (host_addr == CMD_OFS) begin
                regs_d.rdata = regs_q.cmd;
            end else if (host_addr == STS_OFS) begin
                regs_d.rdata = status_word;
            end else begin
                regs_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cmd_word   = regs_q.cmd;
    assign host_rdata = regs_q.rdata;

    // R1: command register only changes on a host write to its offset
    p_cmd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == CMD_OFS) |=> $stable(cmd_word));

    // R1: read data holds between reads
    p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));
endmodule

// File: rtl/mbx_handshake.sv
module mbx_handshake (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req,
    input  logic                      txn_write,
    input  logic                      rsp_valid,
    input  logic [mbx_pkg::PAY_W-1:0] rsp_data,
    output logic                      start,
    output logic                      busy,
    output logic                      ack,
    output logic [mbx_pkg::PAY_W-1:0] resp
);
    import mbx_pkg::*;

    typedef struct packed {
        mbx_state_e       state;
        logic [PAY_W-1:0] resp;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        hs_d  = hs_q;
        start = 1'b0;
        case (hs_q.state)
            ST_IDLE: begin
                if (req) begin
                    start      = 1'b1;
                    hs_d.state = ST_ISSUE;
                end
            end
            ST_ISSUE, ST_WAIT: begin
                if (rsp_valid) begin
                    hs_d.state = ST_ACK;
                    hs_d.resp  = txn_write ? '0 : rsp_data;
                end else begin
                    hs_d.state = ST_WAIT;
                end
            end
            ST_ACK: begin
                if (!req) begin
                    hs_d.state = ST_IDLE;
                    hs_d.resp  = '0;
                end
            end
            default: hs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '{state: ST_IDLE, resp: '0};
        end else begin
            hs_q <= hs_d;
        end
    end

    assign busy = (hs_q.state == ST_ISSUE) || (hs_q.state == ST_WAIT);
    assign ack  = (hs_q.state == ST_ACK);
    assign resp = hs_q.resp;

    // R4: busy and acknowledge exclusive
    p_busy_ack_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && ack));

    // R5: a response during a transaction raises acknowledge next cycle
    p_rsp_to_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rsp_valid) |=> ack);

    // R6: acknowledge holds while the strobe is set
    p_ack_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req) |=> ack);

    // R6: acknowledge drops after the strobe is cleared
    p_ack_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req) |=> (!ack && resp == '0));

    // R8: response field stable while acknowledge stays high
    p_resp_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ack)) |-> $stable(resp));

    // R9: a stray response while idle changes nothing
    p_stray_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ack && !req) |=> (!ack && resp == '0));
endmodule

// File: rtl/mbx_attr_port.sv
module mbx_attr_port (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  mbx_pkg::mbx_cmd_t          cmd,
    output logic                       attr_valid,
    output logic                       attr_write,
    output logic [mbx_pkg::CODE_W-1:0] attr_code,
    output logic [mbx_pkg::PAY_W-1:0]  attr_wdata
);
    import mbx_pkg::*;

    typedef struct packed {
        logic     valid;
        mbx_cmd_t cmd;
    } port_t;

    port_t port_d, port_q;

    always_comb begin
        port_d       = port_q;
        port_d.valid = start;
        if (start) begin
            port_d.cmd = cmd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign attr_valid = port_q.valid;
    assign attr_write = port_q.cmd.write;
    assign attr_code  = port_q.cmd.code;
    assign attr_wdata = port_q.cmd.payload;

    // R2: request pulse lasts one cycle
    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        attr_valid |=> !attr_valid);

    // R8: latched fields only move on a launch
    p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable({attr_write, attr_code, attr_wdata}));
endmodule

// File: rtl/attr_mailbox.sv
module attr_mailbox #(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] CMD_OFS = 'h00,
    parameter logic [ADDR_W-1:0] STS_OFS = 'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              attr_valid,
    output logic              attr_write,
    output logic [7:0]        attr_code,
    output logic [15:0]       attr_wdata,
    input  logic              attr_rsp_valid,
    input  logic [15:0]       attr_rdata
);
    import mbx_pkg::*;

    localparam int LOW_PAD = BSY_BIT;

    logic [WORD_W-1:0] cmd_word;
    logic [WORD_W-1:0] status_word;
    logic              start;
    logic              busy;
    logic              ack;
    logic [PAY_W-1:0]  resp;
    mbx_cmd_t          cmd_fields;

    always_comb begin
        cmd_fields.write   = cmd_word[WR_BIT];
        cmd_fields.code    = cmd_word[CODE_W-1:0];
        cmd_fields.payload = cmd_word[PAY_LSB +: PAY_W];
    end

    assign status_word = {resp, ack, busy, {LOW_PAD{1'b0}}};

    mbx_host_regs #(
        .ADDR_W  (ADDR_W),
        .CMD_OFS (CMD_OFS),
        .STS_OFS (STS_OFS)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .status_word (status_word),
        .cmd_word    (cmd_word),
        .host_rdata  (host_rdata)
    );

    mbx_handshake u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (cmd_word[REQ_BIT]),
        .txn_write (attr_write),
        .rsp_valid (attr_rsp_valid),
        .rsp_data  (attr_rdata),
        .start     (start),
        .busy      (busy),
        .ack       (ack),
        .resp      (resp)
    );

    mbx_attr_port u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmd        (cmd_fields),
        .attr_valid (attr_valid),
        .attr_write (attr_write),
        .attr_code  (attr_code),
        .attr_wdata (attr_wdata)
    );

    // R7: a launch only follows a cycle with acknowledge low
    p_launch_after_ack_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        attr_valid |-> !$past(ack));

    // R4: busy is raised together with the launch pulse
    p_busy_on_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        attr_valid |-> (busy && !ack));
endmodule

// File: tb/attr_mailbox_tb.sv
module attr_mailbox_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        attr_valid;
    logic        attr_write;
    logic [7:0]  attr_code;
    logic [15:0] attr_wdata;
    logic        attr_rsp_valid = 1'b0;
    logic [15:0] attr_rdata = '0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // target model state
    int          tgt_lat = 0;
    logic [15:0] tgt_rsp = '0;
    int          seen_cnt = 0;
    logic [7:0]  seen_code = '0;
    logic        seen_wr = 1'b0;
    logic [15:0] seen_pay = '0;
    bit          stray_go = 1'b0;

    localparam logic [7:0] CMD_A = 8'h00;
    localparam logic [7:0] STS_A = 8'h04;

    always #5 clk = ~clk;

    attr_mailbox u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .attr_valid(attr_valid), .attr_write(attr_write), .attr_code(attr_code),
        .attr_wdata(attr_wdata), .attr_rsp_valid(attr_rsp_valid), .attr_rdata(attr_rdata)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  code;
        logic [15:0] pay;
        logic [15:0] rsp;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h40, 16'h0006, 16'hDEAD, 4'd0},
        '{1'b1, 8'h41, 16'h030C, 16'h1111, 4'd3},
        '{1'b0, 8'h0D, 16'h0000, 16'h0001, 4'd1},
        '{1'b1, 8'h42, 16'h0123, 16'h2222, 4'd6},
        '{1'b0, 8'h49, 16'h0000, 16'h0003, 4'd0},
        '{1'b0, 8'h4A, 16'h0000, 16'h0ABC, 4'd9},
        '{1'b1, 8'h0F, 16'h0020, 16'h3333, 4'd2},
        '{1'b0, 8'h4C, 16'h0000, 16'hF00D, 4'd4}
    };

    function automatic logic [31:0] mk_cmd(input logic wr, input logic req,
                                           input logic [7:0] code, input logic [15:0] pay);
        return {pay, req, 1'b0, wr, 5'b0, code};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic poll(input logic want_ack, output logic [31:0] st);
        for (int i = 0; i < 64; i++) begin
            hread(STS_A, st);
            if (st[15] == want_ack && st[14] == 1'b0) return;
        end
    endtask

    // target model: responds after tgt_lat further cycles
    initial begin
        forever begin
            @(negedge clk);
            if (attr_valid) begin
                seen_cnt++;
                seen_code = attr_code;
                seen_wr   = attr_write;
                seen_pay  = attr_wdata;
                repeat (tgt_lat) @(negedge clk);
                attr_rsp_valid = 1'b1;
                attr_rdata     = tgt_rsp;
                @(negedge clk);
                attr_rsp_valid = 1'b0;
                attr_rdata     = '0;
            end else if (stray_go) begin
                attr_rsp_valid = 1'b1;
                attr_rdata     = 16'h5A5A;
                @(negedge clk);
                attr_rsp_valid = 1'b0;
                attr_rdata     = '0;
                stray_go       = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] st;
        logic [31:0] rd;
        int          cnt0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: status is zero after reset; R1: command reads zero
        hread(STS_A, st);
        check("R3 reset status", st, 32'h0);
        hread(CMD_A, rd);
        check("R1 reset cmd", rd, 32'h0);
        check("R2 no pulse at reset", {31'b0, attr_valid}, 32'h0);

        // R1: readback and unmapped offset
        hwrite(CMD_A, mk_cmd(1'b1, 1'b0, 8'h55, 16'hBEEF));
        hread(CMD_A, rd);
        check("R1 cmd readback", rd, mk_cmd(1'b1, 1'b0, 8'h55, 16'hBEEF));
        hread(8'h08, rd);
        check("R1 unmapped read", rd, 32'h0);
        check("R7 no launch without strobe", seen_cnt, 0);

        // table of transactions: R2, R5, R6, R9
        for (int v = 0; v < NV; v++) begin
            tgt_lat = int'(VECS[v].lat);
            tgt_rsp = VECS[v].rsp;
            cnt0 = seen_cnt;
            hwrite(CMD_A, mk_cmd(VECS[v].wr, 1'b1, VECS[v].code, VECS[v].pay));
            poll(1'b1, st);
            check("R2 one launch", seen_cnt - cnt0, 1);
            check("R2 code at port", {24'b0, seen_code}, {24'b0, VECS[v].code});
            check("R2 write flag", {31'b0, seen_wr}, {31'b0, VECS[v].wr});
            check("R2 payload", {16'b0, seen_pay}, {16'b0, VECS[v].pay});
            check("R5 status on ack", st,
                  {(VECS[v].wr ? 16'h0 : VECS[v].rsp), 1'b1, 1'b0, 14'b0});
            repeat (4) @(negedge clk);
            hread(STS_A, rd);
            check("R6 ack held with strobe set", rd, st);
            hwrite(CMD_A, mk_cmd(VECS[v].wr, 1'b0, VECS[v].code, VECS[v].pay));
            poll(1'b0, st);
            check("R6 status after clear", st, 32'h0);
        end

        // R4 busy and R8 field hold during a slow response
        tgt_lat = 8;
        tgt_rsp = 16'h7E57;
        cnt0 = seen_cnt;
        hwrite(CMD_A, mk_cmd(1'b0, 1'b1, 8'h4B, 16'h0000));
        hread(STS_A, st);
        hread(STS_A, st);
        check("R4 busy during wait", st, {16'h0, 1'b0, 1'b1, 14'b0});
        hwrite(CMD_A, mk_cmd(1'b1, 1'b1, 8'h77, 16'h9999));
        check("R8 code held", {24'b0, attr_code}, {24'b0, 8'h4B});
        check("R8 write flag held", {31'b0, attr_write}, 32'h0);
        poll(1'b1, st);
        check("R7 no launch while busy", seen_cnt - cnt0, 1);
        check("R5 read data after wait", st, {16'h7E57, 1'b1, 1'b0, 14'b0});

        // R7 strobe rewritten while ack high
        hwrite(CMD_A, mk_cmd(1'b0, 1'b1, 8'h4C, 16'h0000));
        repeat (10) @(negedge clk);
        check("R7 no launch while ack", seen_cnt - cnt0, 1);
        hread(STS_A, rd);
        check("R8 response stable", rd, {16'h7E57, 1'b1, 1'b0, 14'b0});
        hwrite(CMD_A, mk_cmd(1'b0, 1'b0, 8'h4C, 16'h0000));
        poll(1'b0, st);
        repeat (5) @(negedge clk);
        check("R7 no launch after clear", seen_cnt - cnt0, 1);
        check("R8 code kept after txn", {24'b0, attr_code}, {24'b0, 8'h4B});

        // R9 stray response while idle
        stray_go = 1'b1;
        repeat (4) @(negedge clk);
        hread(STS_A, st);
        check("R9 stray response ignored", st, 32'h0);

        // R7 back-to-back: new transaction after ack is low
        tgt_lat = 0;
        tgt_rsp = 16'h0042;
        hwrite(CMD_A, mk_cmd(1'b0, 1'b1, 8'h41, 16'h0000));
        poll(1'b1, st);
        check("R7 new launch after ack low", seen_cnt - cnt0, 2);
        check("R9 zero-latency read", st, {16'h0042, 1'b1, 1'b0, 14'b0});
        hwrite(CMD_A, mk_cmd(1'b0, 1'b0, 8'h41, 16'h0000));
        poll(1'b0, st);
        check("R6 final clear", st, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule